// File: doc/BRIEF.md
# Single-Cycle Integer ALU Core

This block is a small processor core that finishes one instruction in every clock cycle. In that one cycle it fetches a word from an on-chip instruction ROM at the program counter, decodes it, reads up to two source registers, runs the ALU and writes the result back into the register file. The instruction set is limited to the register-register and register-immediate arithmetic and logic group of the 32-bit base integer RISC-V set: ADD, SUB, AND, OR, XOR, SLL, SRL, SRA, ADDI, ANDI, ORI and XORI. Anything else is a no-op. There are no loads, stores, branches, jumps or upper-immediate instructions.

The ROM is filled through a load port while reset is held. When reset is released, execution starts at address 0. A set of debug outputs shows the program counter, the fetched word and the write-back activity of the current cycle, so an environment can follow every register update from outside.

Top module: `sc_int_core`

## Requirements
- R1: The program counter is 0 while `rst` is high. After reset it rises by 4 on every clock edge and stays word-aligned.
- R2: `dbg_instr` is the ROM word at index PC[31:2]. The ROM is written through `load_en`/`load_addr`/`load_data` on clock edges where `rst` is high. A load request made while `rst` is low changes nothing.
- R3: When PC[31:2] is at or beyond `ROM_WORDS`, the fetched word is 0x00000013, and that cycle makes no register write.
- R4: Register x0 always reads as zero. An instruction with rd = 0 leaves `dbg_wb_en` low.
- R5: R-type instructions (opcode 0110011) compute ADD (funct3 000, funct7 0000000), SUB (000, 0100000), XOR (100), OR (110) and AND (111) on the two register operands. An instruction reads a register written by the instruction just before it and gets the new value.
- R6: I-type instructions (opcode 0010011) ADDI (funct3 000), XORI (100), ORI (110) and ANDI (111) use bits [31:20] sign-extended to 32 bits as the second operand.
- R7: An unknown opcode, an unsupported funct3, or an unsupported funct7 causes no register write, and the PC still advances by 4.
- R8: With 0x00500093, 0x00A00113 and 0x002081B3 at ROM words 0 to 2, the first three cycles after reset write x1=5, x2=10 and x3=15.
- R9: SLL (funct3 001, funct7 0000000), SRL (101, 0000000) and SRA (101, 0100000) shift by the low 5 bits of rs2. SRA fills the vacated bits with the sign bit.
- R10: While `rst` is high, no register write takes place and `dbg_wb_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also enables ROM loading |
| load_en | input | 1 | ROM write strobe, honoured only during reset |
| load_addr | input | ROM_AW | ROM word index to write |
| load_data | input | 32 | Instruction word to write |
| dbg_pc | output | 32 | Program counter of the current cycle |
| dbg_instr | output | 32 | Instruction fetched in the current cycle |
| dbg_wb_en | output | 1 | A register is written at the end of this cycle |
| dbg_wb_rd | output | 5 | Destination register of that write |
| dbg_wb_data | output | 32 | Value being written |

## Verification
The case that is hardest to reach from the ports is a PC that has run past the last ROM word. The only way to move the PC is to let it count, so the bench runs a long program straight through all 256 words and a few cycles beyond. The same run also tries a load request with reset low and later fetches the targeted word, to show that it kept its old content. Register contents can only be seen through write-back, so the programs copy earlier results into fresh registers. This makes a corrupted x0 or a lost write visible on `dbg_wb_data`.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;
  localparam int XLEN = 32;
  localparam int NREG = 32;
  localparam int RAW  = $clog2(NREG);

  localparam logic [6:0]      OPC_REG  = 7'b0110011;
  localparam logic [6:0]      OPC_IMM  = 7'b0010011;
  localparam logic [XLEN-1:0] NOP_WORD = 32'h0000_0013;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_SLL, ALU_SRL, ALU_SRA, ALU_XOR, ALU_OR, ALU_AND
  } alu_op_e;

  typedef struct packed {
    logic [RAW-1:0]  rs1;
    logic [RAW-1:0]  rs2;
    logic [RAW-1:0]  rd;
    logic [XLEN-1:0] imm;
    logic            use_imm;
    alu_op_e         op;
    logic            wr;
  } dec_t;
endpackage

// File: rtl/sc_fetch.sv
module sc_fetch
  import sc_core_pkg::*;
#(
  parameter int ROM_WORDS = 256,
  localparam int AW = $clog2(ROM_WORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_en,
  input  logic [AW-1:0]   load_addr,
  input  logic [XLEN-1:0] load_data,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] instr
);
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] rom [ROM_WORDS];
  logic            in_range;

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + XLEN'(4);
  end

  always_ff @(posedge clk) begin
    if (rst && load_en) rom[load_addr] <= load_data;
  end

  assign in_range = ({2'b00, pc_q[XLEN-1:2]} < XLEN'(ROM_WORDS));
  assign instr    = in_range ? rom[pc_q[AW+1:2]] : NOP_WORD;
  assign pc       = pc_q;

  p_pc_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> pc_q == $past(pc_q) + XLEN'(4));
  p_pc_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);
  p_beyond_rom_nop_r3: assert property (@(posedge clk) disable iff (rst)
    ({2'b00, pc_q[XLEN-1:2]} >= XLEN'(ROM_WORDS)) |-> instr == NOP_WORD);
endmodule

// File: rtl/sc_decode.sv
module sc_decode
  import sc_core_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic       legal;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  always_comb begin
    dec         = '0;
    dec.rs1     = instr[19:15];
    dec.rs2     = instr[24:20];
    dec.rd      = instr[11:7];
    dec.imm     = {{(XLEN-12){instr[31]}}, instr[31:20]};
    dec.op      = ALU_ADD;
    legal       = 1'b0;
    if (opc == OPC_REG) begin
      dec.use_imm = 1'b0;
      if (f7 == 7'b0000000) begin
        legal = (f3 != 3'b010) && (f3 != 3'b011);
        case (f3)
          3'b001:  dec.op = ALU_SLL;
          3'b100:  dec.op = ALU_XOR;
          3'b101:  dec.op = ALU_SRL;
          3'b110:  dec.op = ALU_OR;
          3'b111:  dec.op = ALU_AND;
          default: dec.op = ALU_ADD;
        endcase
      end else if (f7 == 7'b0100000) begin
        legal  = (f3 == 3'b000) || (f3 == 3'b101);
        dec.op = (f3 == 3'b101) ? ALU_SRA : ALU_SUB;
      end
    end else if (opc == OPC_IMM) begin
      dec.use_imm = 1'b1;
      case (f3)
        3'b000:  begin dec.op = ALU_ADD; legal = 1'b1; end
        3'b100:  begin dec.op = ALU_XOR; legal = 1'b1; end
        3'b110:  begin dec.op = ALU_OR;  legal = 1'b1; end
        3'b111:  begin dec.op = ALU_AND; legal = 1'b1; end
        default: legal = 1'b0;
      endcase
    end
    dec.wr = legal && (dec.rd != '0);
  end
endmodule

// File: rtl/sc_regbank.sv
module sc_regbank
  import sc_core_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RAW-1:0]  waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RAW-1:0]  ra1,
  output logic [XLEN-1:0] rd1,
  input  logic [RAW-1:0]  ra2,
  output logic [XLEN-1:0] rd2
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we) regs[waddr] <= wdata;
  end

  assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
  assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

  always_ff @(posedge clk) begin
    p_reset_quiet_r10: assert (!(rst && we));
  end

  p_x0_no_write_r4: assert property (@(posedge clk) disable iff (rst)
    we |-> waddr != '0);
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_core_pkg::*;
(
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  alu_op_e         op,
  output logic [XLEN-1:0] y
);
  localparam int SHW = $clog2(XLEN);
  logic [SHW-1:0] sh;

  assign sh = b[SHW-1:0];

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_SLL: y = a << sh;
      ALU_SRL: y = a >> sh;
      ALU_SRA: y = $unsigned($signed(a) >>> sh);
      ALU_XOR: y = a ^ b;
      ALU_OR:  y = a | b;
      default: y = a & b;
    endcase
  end
endmodule

// File: rtl/sc_int_core.sv
module sc_int_core
  import sc_core_pkg::*;
#(
  parameter int ROM_WORDS = 256,
  localparam int ROM_AW = $clog2(ROM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ROM_AW-1:0] load_addr,
  input  logic [XLEN-1:0]   load_data,
  output logic [XLEN-1:0]   dbg_pc,
  output logic [XLEN-1:0]   dbg_instr,
  output logic              dbg_wb_en,
  output logic [RAW-1:0]    dbg_wb_rd,
  output logic [XLEN-1:0]   dbg_wb_data
);
  logic [XLEN-1:0] pc, instr, opa, opb_reg, opb, res;
  dec_t            dec;
  logic            wr_go;

  sc_fetch #(.ROM_WORDS(ROM_WORDS)) u_fetch (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .pc(pc), .instr(instr)
  );

  sc_decode u_dec (.instr(instr), .dec(dec));

  assign wr_go = dec.wr && !rst;

  sc_regbank u_rf (
    .clk(clk), .rst(rst), .we(wr_go), .waddr(dec.rd), .wdata(res),
    .ra1(dec.rs1), .rd1(opa), .ra2(dec.rs2), .rd2(opb_reg)
  );

  assign opb = dec.use_imm ? dec.imm : opb_reg;

  sc_alu u_alu (.a(opa), .b(opb), .op(dec.op), .y(res));

  assign dbg_pc      = pc;
  assign dbg_instr   = instr;
  assign dbg_wb_en   = wr_go;
  assign dbg_wb_rd   = dec.rd;
  assign dbg_wb_data = res;

  p_unknown_opc_r7: assert property (@(posedge clk) disable iff (rst)
    (instr[6:0] != OPC_REG && instr[6:0] != OPC_IMM) |-> !dbg_wb_en);
  p_nop_fill_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (instr == NOP_WORD) |-> !dbg_wb_en);
endmodule

// File: tb/sc_int_core_tb.sv
module sc_int_core_tb;
  localparam int WORDS = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_en = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] dbg_pc, dbg_instr, dbg_wb_data;
  logic        dbg_wb_en;
  logic [4:0]  dbg_wb_rd;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] rom_m [WORDS];
  logic [31:0] rf_m  [32];
  logic [31:0] pc_m;

  always #4 clk = ~clk;

  sc_int_core #(.ROM_WORDS(WORDS)) u_dut (
    .clk(clk), .rst(rst), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .dbg_pc(dbg_pc), .dbg_instr(dbg_instr),
    .dbg_wb_en(dbg_wb_en), .dbg_wb_rd(dbg_wb_rd), .dbg_wb_data(dbg_wb_data)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h (pc_model 0x%08h)", req, got, exp, pc_m);
    end
  endtask

  function automatic logic [31:0] enc_r(input logic [6:0] f7, input int rs2, input int rs1,
                                        input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'h33};
  endfunction

  function automatic logic [31:0] enc_i(input int imm, input int rs1, input logic [2:0] f3,
                                        input int rd);
    return {12'(imm), 5'(rs1), f3, 5'(rd), 7'h13};
  endfunction

  // Behavioural expectation for one instruction.
  task automatic emulate(input logic [31:0] ins, output bit en, output logic [4:0] rd,
                         output logic [31:0] val, output string tag);
    logic [31:0] a, b, imm;
    logic [2:0]  f3;
    logic [6:0]  f7;
    bit ok;
    f3  = ins[14:12];
    f7  = ins[31:25];
    rd  = ins[11:7];
    a   = (ins[19:15] == 0) ? 32'd0 : rf_m[ins[19:15]];
    b   = (ins[24:20] == 0) ? 32'd0 : rf_m[ins[24:20]];
    imm = 32'($signed(ins[31:20]));
    ok  = 0; val = 0; tag = "R7";
    if (ins[6:0] == 7'h13) begin
      tag = "R6"; ok = 1;
      if (f3 == 0)      val = a + imm;
      else if (f3 == 4) val = a ^ imm;
      else if (f3 == 6) val = a | imm;
      else if (f3 == 7) val = a & imm;
      else begin ok = 0; tag = "R7"; end
    end else if (ins[6:0] == 7'h33) begin
      tag = "R5"; ok = 1;
      if (f7 == 7'h00 && f3 == 0)      val = a + b;
      else if (f7 == 7'h20 && f3 == 0) val = a - b;
      else if (f7 == 7'h00 && f3 == 4) val = a ^ b;
      else if (f7 == 7'h00 && f3 == 6) val = a | b;
      else if (f7 == 7'h00 && f3 == 7) val = a & b;
      else if (f7 == 7'h00 && f3 == 1) begin val = a << (b % 32); tag = "R9"; end
      else if (f7 == 7'h00 && f3 == 5) begin val = a >> (b % 32); tag = "R9"; end
      else if (f7 == 7'h20 && f3 == 5) begin val = 32'($signed(a) >>> (b % 32)); tag = "R9"; end
      else begin ok = 0; tag = "R7"; end
    end
    en = ok;
    if (ok && rd == 0) begin en = 0; tag = "R4"; end
  endtask

  task automatic load_program(input logic [31:0] prog [$]);
    rst = 1'b1;
    for (int i = 0; i < WORDS; i++) begin
      rom_m[i] = (i < prog.size()) ? prog[i] : 32'h0000_0013;
      @(negedge clk);
      load_en = 1'b1; load_addr = 8'(i); load_data = rom_m[i];
    end
    @(negedge clk);
    load_en = 1'b0;
    @(negedge clk);
    #1;
    check("R10 wb_en in reset", 32'(dbg_wb_en), 32'd0);
    check("R1 pc in reset", dbg_pc, 32'd0);
    pc_m = 0;
  endtask

  // Runs ncyc cycles; optional blocked load attempt at cycle bad_cyc.
  task automatic run(input int ncyc, input bit demo, input int bad_cyc);
    bit en; logic [4:0] rd; logic [31:0] val, exp_ins; string tag;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 1; c <= ncyc; c++) begin
      #1;
      exp_ins = ((pc_m >> 2) < WORDS) ? rom_m[pc_m >> 2] : 32'h0000_0013;
      check("R1 pc", dbg_pc, pc_m);
      check(((pc_m >> 2) < WORDS) ? "R2 instr" : "R3 instr past rom", dbg_instr, exp_ins);
      emulate(exp_ins, en, rd, val, tag);
      if ((pc_m >> 2) >= WORDS) tag = "R3";
      if (demo && c <= 3) tag = "R8";
      check({tag, " wb_en"}, 32'(dbg_wb_en), 32'(en));
      if (en) begin
        check({tag, " wb_rd"}, 32'(dbg_wb_rd), 32'(rd));
        check({tag, " wb_data"}, dbg_wb_data, val);
        rf_m[rd] = val;
      end
      pc_m = pc_m + 4;
      if (c == bad_cyc) begin
        load_en = 1'b1; load_addr = 8'd100; load_data = 32'hFFFF_FFFF;
      end
      @(negedge clk);
      load_en = 1'b0;
    end
    rst = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] p [$];
    for (int i = 0; i < 32; i++) rf_m[i] = 0;
    pc_m = 0;
    repeat (2) @(negedge clk);

    // R8 demo program
    p = '{32'h0050_0093, 32'h00A0_0113, 32'h0020_81B3};
    load_program(p);
    run(6, 1'b1, 0);

    // Long program: ALU ops, x0, no-ops, blocked load (R2), run past ROM end (R3)
    p = '{};
    p.push_back(enc_i(-5, 0, 3'd0, 1));
    p.push_back(enc_i(12'h7FF, 0, 3'd0, 2));
    p.push_back(enc_r(7'h00, 2, 1, 3'd0, 3));
    p.push_back(enc_r(7'h20, 2, 1, 3'd0, 4));
    p.push_back(enc_i(-1, 2, 3'd4, 5));
    p.push_back(enc_i(12'h0F0, 1, 3'd6, 6));
    p.push_back(enc_i(12'h0F0, 2, 3'd7, 7));
    p.push_back(enc_i(33, 0, 3'd0, 8));
    p.push_back(enc_r(7'h00, 8, 2, 3'd1, 9));
    p.push_back(enc_r(7'h00, 8, 1, 3'd5, 10));
    p.push_back(enc_r(7'h20, 8, 1, 3'd5, 11));
    p.push_back(enc_r(7'h00, 2, 1, 3'd7, 12));
    p.push_back(enc_r(7'h00, 2, 1, 3'd6, 13));
    p.push_back(enc_r(7'h00, 2, 1, 3'd4, 14));
    p.push_back(enc_i(7, 1, 3'd0, 0));
    p.push_back(enc_r(7'h00, 0, 0, 3'd0, 15));
    p.push_back(32'h0000_2083);
    p.push_back(enc_i(1, 1, 3'd2, 16));
    p.push_back(enc_r(7'h01, 2, 1, 3'd0, 17));
    p.push_back(enc_r(7'h20, 2, 1, 3'd7, 18));
    p.push_back(enc_r(7'h00, 0, 3, 3'd0, 19));
    p.push_back(enc_r(7'h00, 2, 1, 3'd3, 20));
    p.push_back(enc_r(7'h20, 1, 4, 3'd5, 21));
    p.push_back(enc_i(-2048, 21, 3'd0, 22));
    load_program(p);
    run(WORDS + 8, 1'b0, 5);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule